// File: doc/BRIEF.md
# Clock Source Settle Tracker and Sleep Sequencer

This block watches six clock sources (a high-speed crystal, a low-speed crystal, a PLL, a 10 kHz RC, a 22 MHz RC and a 48 MHz RC) and decides when each can be used. When a source is switched on, a dedicated settle counter advances on each reference tick. The source's stable flag rises only when that counter reaches a per-source threshold. The six flags form a status word. A per-source usable output combines the enable with the flag.

The block also sequences chip sleep. Sleep is entered only when software has armed it and a wait-for-interrupt pulse arrives. While asleep, the high-speed crystal and both fast RC oscillators have their run outputs forced low. On entry, the flags of the high-speed crystal, the PLL and the 22 MHz RC are wiped. A wake-up interrupt moves the sequencer to a one-cycle wake state and then back to run. From there, each wiped source that is still switched on settles again from zero.

Top module: `clk_stab_pd_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every settle counter and every stable flag and puts the sequencer in run. The state code is 0 for run, 1 for sleep and 2 for wake.
- R2: The status word has these bit positions: 0 high-speed crystal, 1 low-speed crystal, 2 PLL, 3 10 kHz RC, 4 22 MHz RC, 5 48 MHz RC. The usable and run outputs use the same positions.
- R3: With a source enabled, its counter advances only on clock edges where the reference tick is high. Its flag reads 1 starting with the edge on which the count reaches that source's threshold (each threshold is at least 1). It then stays at 1 without wrapping.
- R4: Each usable bit equals that source's enable AND its stable flag. A usable bit therefore drops in the same cycle its enable falls.
- R5: Switching a source off clears its counter, and its status bit reads 0 from the next clock edge.
- R6: Sleep is entered at the edge where the sleep-arm input and the wait-for-interrupt pulse are both high in run. Either one alone leaves the sequencer in run.
- R7: In sleep, the run outputs of the high-speed crystal, the 22 MHz RC and the 48 MHz RC are 0. Every other run bit equals its enable.
- R8: At sleep entry, the flags of the high-speed crystal, the PLL and the 22 MHz RC clear and stay 0 throughout sleep. The other three flags keep their value, and the 48 MHz RC counter is frozen.
- R9: The sequencer stays in sleep until the wake-up interrupt, then spends exactly one cycle in wake before returning to run. A wiped source that is still enabled starts counting from zero in the wake cycle. A source disabled during sleep stays at 0.
- R10: A wake-up interrupt that arrives while the sequencer is in run has no effect.
- R11: The PLL counts as enabled only while its power-down input is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Reference tick; settle counters advance on edges where it is high |
| xtal_hi_en | input | 1 | High-speed crystal enable |
| xtal_lo_en | input | 1 | Low-speed crystal enable |
| pll_powerdown | input | 1 | PLL power-down; PLL enabled when 0 |
| rc10k_en | input | 1 | 10 kHz RC enable |
| rc22_en | input | 1 | 22 MHz RC enable |
| rc48_en | input | 1 | 48 MHz RC enable |
| sleep_arm | input | 1 | Software sleep arm |
| wfi_pulse | input | 1 | Wait-for-interrupt event |
| wake_irq | input | 1 | Wake-up interrupt |
| stable_status | output | 6 | Stable flags, bit order per R2 |
| src_usable | output | 6 | Enable AND stable per source |
| osc_run | output | 6 | Per-source run command after sleep gating |
| pwr_state | output | 2 | Sequencer state: 0 run, 1 sleep, 2 wake |

## Verification
The in-RTL properties assume the reset is held for at least one edge before any check applies, and that thresholds are nonzero. They place no constraint on the timing of the interrupt inputs. The stimulus keeps tick high except in one window that tests the tick qualification. It applies wait-for-interrupt and wake-up as short pulses and changes enables only between edges. The sequence covers arm without pulse, pulse without arm, a wake interrupt in run, and a source disabled during sleep, so each guarded path is reached at least once.

// File: rtl/clk_stab_pkg.sv
package clk_stab_pkg;

    localparam int unsigned NSRC = 6;

    localparam int unsigned SRC_XHI   = 0;
    localparam int unsigned SRC_XLO   = 1;
    localparam int unsigned SRC_PLL   = 2;
    localparam int unsigned SRC_RC10K = 3;
    localparam int unsigned SRC_RC22  = 4;
    localparam int unsigned SRC_RC48  = 5;

    // Sources whose run output is forced low while asleep
    localparam logic [NSRC-1:0] SLEEP_GATE_MASK =
        (NSRC'(1) << SRC_XHI) | (NSRC'(1) << SRC_RC22) | (NSRC'(1) << SRC_RC48);
    // Sources whose stable flag is wiped on sleep entry
    localparam logic [NSRC-1:0] SLEEP_WIPE_MASK =
        (NSRC'(1) << SRC_XHI) | (NSRC'(1) << SRC_RC22) | (NSRC'(1) << SRC_PLL);

    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_SLEEP = 2'd1,
        PS_WAKE  = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic            arm;
        logic [NSRC-1:0] src_en;
    } ctl_req_t;

    function automatic ctl_req_t pack_requests(
        input logic xhi, input logic xlo, input logic pll_pd,
        input logic rc10k, input logic rc22, input logic rc48,
        input logic arm
    );
        ctl_req_t r;
        r.arm               = arm;
        r.src_en            = '0;
        r.src_en[SRC_XHI]   = xhi;
        r.src_en[SRC_XLO]   = xlo;
        r.src_en[SRC_PLL]   = ~pll_pd;
        r.src_en[SRC_RC10K] = rc10k;
        r.src_en[SRC_RC22]  = rc22;
        r.src_en[SRC_RC48]  = rc48;
        return r;
    endfunction

endpackage

// File: rtl/stab_counter.sv
module stab_counter #(
    parameter int unsigned THRESH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic en,
    input  logic wipe,
    input  logic freeze,
    output logic stable
);
    localparam int unsigned CW = $clog2(THRESH + 1);
    localparam logic [CW-1:0] LIMIT = CW'(THRESH);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en || wipe) begin
            cnt_q <= '0;
        end else if (tick && !freeze && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign stable = (cnt_q == LIMIT);

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !en |=> !stable);  // R5
    AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(stable) |-> ($past(tick) && !$past(freeze)));  // R3
    AST_STABLE_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (stable && en && !wipe) |=> stable);  // R3
    AST_WIPE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        wipe |=> !stable);  // R8

endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
    import clk_stab_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       arm,
    input  logic       wfi,
    input  logic       wake_irq,
    output pwr_state_e state,
    output logic       sleep_entry
);
    pwr_state_e state_d;

    assign sleep_entry = (state == PS_RUN) && arm && wfi;

    always_comb begin
        state_d = state;
        unique case (state)
            PS_RUN:   if (sleep_entry) state_d = PS_SLEEP;
            PS_SLEEP: if (wake_irq)    state_d = PS_WAKE;
            PS_WAKE:                   state_d = PS_RUN;
            default:                   state_d = PS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PS_RUN;
        else     state <= state_d;
    end

    AST_SLEEP_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        (state == PS_SLEEP && $past(state) == PS_RUN) |-> $past(arm && wfi));  // R6
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (state == PS_WAKE) |=> (state == PS_RUN));  // R9
    AST_SLEEP_UNTIL_IRQ: assert property (@(posedge clk) disable iff (rst)
        (state == PS_SLEEP && !wake_irq) |=> (state == PS_SLEEP));  // R9
    AST_IRQ_IGNORED_RUN: assert property (@(posedge clk) disable iff (rst)
        (state == PS_RUN && !(arm && wfi)) |=> (state == PS_RUN));  // R10

endmodule

// File: rtl/clk_stab_pd_ctrl.sv
module clk_stab_pd_ctrl
    import clk_stab_pkg::*;
#(
    parameter int unsigned SETTLE_XHI   = 4096,
    parameter int unsigned SETTLE_XLO   = 16384,
    parameter int unsigned SETTLE_PLL   = 2048,
    parameter int unsigned SETTLE_RC10K = 64,
    parameter int unsigned SETTLE_RC22  = 256,
    parameter int unsigned SETTLE_RC48  = 512
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       xtal_hi_en,
    input  logic       xtal_lo_en,
    input  logic       pll_powerdown,
    input  logic       rc10k_en,
    input  logic       rc22_en,
    input  logic       rc48_en,
    input  logic       sleep_arm,
    input  logic       wfi_pulse,
    input  logic       wake_irq,
    output logic [5:0] stable_status,
    output logic [5:0] src_usable,
    output logic [5:0] osc_run,
    output logic [1:0] pwr_state
);
    localparam int unsigned THRESH_TAB [NSRC] = '{
        SETTLE_XHI, SETTLE_XLO, SETTLE_PLL,
        SETTLE_RC10K, SETTLE_RC22, SETTLE_RC48
    };

    ctl_req_t   req;
    pwr_state_e state;
    logic       sleep_entry;
    logic       asleep;

    assign req = pack_requests(xtal_hi_en, xtal_lo_en, pll_powerdown,
                               rc10k_en, rc22_en, rc48_en, sleep_arm);

    pd_sequencer u_seq (
        .clk         (clk),
        .rst         (rst),
        .arm         (req.arm),
        .wfi         (wfi_pulse),
        .wake_irq    (wake_irq),
        .state       (state),
        .sleep_entry (sleep_entry)
    );

    assign asleep    = (state == PS_SLEEP);
    assign pwr_state = state;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic wipe_i;
        logic freeze_i;

        if (SLEEP_WIPE_MASK[i]) begin : g_wipe
            assign wipe_i = sleep_entry || asleep;
        end else begin : g_keep
            assign wipe_i = 1'b0;
        end

        if (SLEEP_GATE_MASK[i]) begin : g_gate
            assign freeze_i   = asleep;
            assign osc_run[i] = req.src_en[i] && !asleep;
        end else begin : g_free
            assign freeze_i   = 1'b0;
            assign osc_run[i] = req.src_en[i];
        end

        stab_counter #(.THRESH(THRESH_TAB[i])) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .en     (req.src_en[i]),
            .wipe   (wipe_i),
            .freeze (freeze_i),
            .stable (stable_status[i])
        );
    end

    assign src_usable = req.src_en & stable_status;

    AST_SLEEP_FLAGS_WIPED: assert property (@(posedge clk) disable iff (rst)
        (state == PS_SLEEP) |-> ((stable_status & SLEEP_WIPE_MASK) == '0));  // R8
    AST_SLEEP_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
        (state == PS_SLEEP) |-> ((osc_run & SLEEP_GATE_MASK) == '0));  // R7
    AST_PLL_OFF_UNSTABLE: assert property (@(posedge clk) disable iff (rst)
        pll_powerdown |=> !stable_status[SRC_PLL]);  // R11
    AST_ENTRY_KEEPS_SLOW: assert property (@(posedge clk) disable iff (rst)
        (sleep_entry && xtal_lo_en && stable_status[SRC_XLO]) |=> stable_status[SRC_XLO]);  // R8

endmodule

// File: tb/clk_stab_pd_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_stab_pd_ctrl_tb_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1, tick = 1'b1;
    logic xtal_hi_en = 0, xtal_lo_en = 0, pll_powerdown = 1;
    logic rc10k_en = 0, rc22_en = 0, rc48_en = 0;
    logic sleep_arm = 0, wfi_pulse = 0, wake_irq = 0;
    logic [5:0] stable_status, src_usable, osc_run;
    logic [1:0] pwr_state;

    clk_stab_pd_ctrl #(
        .SETTLE_XHI(4), .SETTLE_XLO(6), .SETTLE_PLL(3),
        .SETTLE_RC10K(2), .SETTLE_RC22(5), .SETTLE_RC48(7)
    ) dut_i (.*);

    int unsigned thr [6] = '{4, 6, 3, 2, 5, 7};
    localparam logic [5:0] GATE = 6'b110001;

    typedef struct {
        string      tag;
        logic [5:0] st;
        logic [5:0] us;
        logic [5:0] run;
        logic [1:0] ps;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    function automatic logic [5:0] en_mask();
        return {rc48_en, rc22_en, rc10k_en, ~pll_powerdown, xtal_lo_en, xtal_hi_en};
    endfunction

    // Driver side: push the expected outputs derived from the requirements
    task automatic expect_out(string tag, logic [5:0] st, logic [1:0] ps);
        exp_t e;
        e.tag = tag;
        e.st  = st;
        e.us  = st & en_mask();
        e.run = en_mask() & ((ps == 2'd1) ? ~GATE : 6'h3F);
        e.ps  = ps;
        exp_q.push_back(e);
        #1;
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: pop each expectation and compare with the live outputs
    initial begin : monitor
        exp_t e;
        forever begin
            wait (exp_q.size() != 0);
            e = exp_q.pop_front();
            n_chk++;
            if (stable_status !== e.st || src_usable !== e.us ||
                osc_run !== e.run || pwr_state !== e.ps) begin
                n_fail++;
                $display("FAIL %s: status=%h usable=%h run=%h state=%0d expected status=%h usable=%h run=%h state=%0d",
                         e.tag, stable_status, src_usable, osc_run, pwr_state,
                         e.st, e.us, e.run, e.ps);
            end
        end
    end

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : driver
        logic [5:0] st;
        step(2);
        rst = 1'b0;
        expect_out("R1 reset state", 6'h00, 2'd0);

        // R2 R3 R4 R11: enable every source, flags rise at their thresholds
        xtal_hi_en = 1; xtal_lo_en = 1; pll_powerdown = 0;
        rc10k_en = 1; rc22_en = 1; rc48_en = 1;
        for (int k = 1; k <= 8; k++) begin
            step(1);
            st = '0;
            for (int i = 0; i < 6; i++) if (k >= int'(thr[i])) st[i] = 1'b1;
            expect_out($sformatf("R2 R3 R4 R11 settle k=%0d", k), st, 2'd0);
        end

        // R10: wake interrupt in run is ignored
        wake_irq = 1; step(2); wake_irq = 0;
        expect_out("R10 wake in run", 6'h3F, 2'd0);

        // R5 / R4: disable the low-speed crystal
        xtal_lo_en = 0;
        expect_out("R4 usable drops same cycle", 6'h3F, 2'd0);
        step(1);
        expect_out("R5 flag cleared", 6'h3D, 2'd0);

        // R3: counting qualified by tick
        tick = 0; xtal_lo_en = 1;
        step(5);
        expect_out("R3 no tick no count", 6'h3D, 2'd0);
        tick = 1;
        step(5);
        expect_out("R3 one short of threshold", 6'h3D, 2'd0);
        step(1);
        expect_out("R3 threshold reached", 6'h3F, 2'd0);

        // R6: either condition alone does not sleep
        wfi_pulse = 1; step(1); wfi_pulse = 0;
        expect_out("R6 pulse without arm", 6'h3F, 2'd0);
        sleep_arm = 1; step(3);
        expect_out("R6 arm without pulse", 6'h3F, 2'd0);

        // R6 R7 R8: enter sleep
        wfi_pulse = 1; step(1); wfi_pulse = 0;
        expect_out("R6 R7 R8 sleep entry", 6'h2A, 2'd1);
        step(3);
        expect_out("R9 R7 stays asleep", 6'h2A, 2'd1);

        // R9: disable the 22 MHz RC while asleep, then wake
        rc22_en = 0;
        expect_out("R9 disable in sleep", 6'h2A, 2'd1);
        wake_irq = 1; step(1); wake_irq = 0;
        expect_out("R9 wake state", 6'h2A, 2'd2);
        for (int k = 2; k <= 6; k++) begin
            step(1);
            st = 6'h2A;
            if (k >= 5) st[0] = 1'b1;
            if (k >= 4) st[2] = 1'b1;
            expect_out($sformatf("R9 resettle k=%0d", k), st, 2'd0);
        end

        // R11: PLL power-down bit
        pll_powerdown = 1;
        expect_out("R11 PLL usable drops", 6'h2F, 2'd0);
        step(1);
        expect_out("R11 PLL flag cleared", 6'h2B, 2'd0);

        done = 1;
        #2;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule